// File: doc/BRIEF.md
# Dual-Source Interrupt Level and Vector Logic

This block is the interrupt front end of a serial module that has two request sources: a queued SPI engine and an SCI. Each source has its own programmable priority level. While a source flag is high and its level is nonzero, the block raises the matching one of seven internal interrupt level lines. When both sources are pending, the higher level is the one presented. On equal levels the SPI source is preferred.

When the CPU runs an interrupt-acknowledge cycle, it presents the level being acknowledged. If that level equals the block's highest pending level and the block's arbitration ID is nonzero, the block joins a bit-serial contention on a shared wired-OR line against other modules. It sends its ID most significant bit first, one bit per clock. It withdraws as soon as it sends a 0 while the line reads 1. The winner places an 8-bit exception vector on the bus for one cycle. The upper vector bits come from one shared vector register, and the lowest bit tells which source is being serviced.

A small register port gives access to the two level fields, the arbitration ID and the vector register. The SPI and SCI datapaths are outside this block; their request flags arrive as inputs.

Top module: `sirq_frontend`

## Requirements
- R1: With effective level L = max(SPI level if SPI flag set, SCI level if SCI flag set), `irq_lines` has exactly bit L-1 set when L is nonzero (bit i stands for level line i+1).
- R2: A level field of 0 disables its source: that source alone never raises any bit of `irq_lines` and never causes a vector.
- R3: When both sources are pending at the same nonzero level, the SPI source is serviced: the delivered vector has bit 0 = 1.
- R4: The block contends and delivers a vector only when `iack_level` equals its highest pending level at the clock edge that first samples `iack`; otherwise `vec_valid` stays low for the whole acknowledge cycle.
- R5: With an arbitration ID of 0, `arb_out` and `vec_valid` stay low for every acknowledge cycle.
- R6: The ID is sent MSB first on `arb_out`, one bit per cycle. A module that drives 0 while `arb_line` is 1 drives 0 from then on and delivers no vector, so the highest ID among the contenders wins.
- R7: On a win, `vec_valid` is high for exactly one cycle, ID_W+1 clock edges after the edge that first samples `iack`. `vec_data` is then {vector register bits 7:1, s}, where s = 1 for SPI and s = 0 for SCI.
- R8: After reset, the vector register reads 0x0F, the level and ID registers read 0, `irq_lines` is 0 and `vec_valid` is 0.
- R9: A write to bit 0 of the vector register (select 2) has no effect, and a read of that register always returns 1 in bit 0.
- R10: A level line stays asserted through and after acknowledgement for as long as the source flag stays high. It falls once the flag is cleared.
- R11: Register select 0 holds the SPI level in bits 2:0 and the SCI level in bits 5:3. Select 1 holds the ID in bits 3:0. Writes read back unchanged in these fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 levels, 1 arbitration ID, 2 vector |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| spi_flag | input | 1 | SPI engine request flag |
| sci_flag | input | 1 | SCI request flag |
| irq_lines | output | 7 | Interrupt level lines; bit i is level i+1 |
| iack | input | 1 | Interrupt-acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| arb_out | output | 1 | This module's bit on the contention line |
| arb_line | input | 1 | Resolved wired-OR contention line |
| vec_valid | output | 1 | Vector strobe, one cycle |
| vec_data | output | 8 | Exception vector |

## Verification
A bad latched source or a level compare on a stale value shows up as a wrong vector bit 0, or as a missing strobe, in the same acknowledge cycle. That is at most ID_W+1 cycles after `iack` rises. A bit counter that is off by one, or a failure to drop out of contention, moves the strobe to the wrong cycle or lets two modules strobe together, and the bench catches this with a second instance on the shared line. Errors in level decode or in the registers show at once on `irq_lines` or on read-back.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_SHIFT = 2'd1,
      ARB_WIN   = 2'd2,
      ARB_HOLD  = 2'd3
   } arb_state_e;

   localparam logic [1:0] SEL_LEVELS = 2'd0;
   localparam logic [1:0] SEL_ARBID  = 2'd1;
   localparam logic [1:0] SEL_VECTOR = 2'd2;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs #(
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned ID_W      = 4,
   parameter int unsigned VEC_W     = 8,
   parameter logic [7:0]  RESET_VEC = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_sel,
   input  logic             reg_we,
   input  logic [VEC_W-1:0] reg_wdata,
   output logic [VEC_W-1:0] reg_rdata,
   output logic [LVL_W-1:0] spi_lvl,
   output logic [LVL_W-1:0] sci_lvl,
   output logic [ID_W-1:0]  arb_id,
   output logic [VEC_W-1:1] vec_hi
);
   import sirq_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_lvl <= '0;
         sci_lvl <= '0;
         arb_id  <= '0;
         vec_hi  <= RESET_VEC[VEC_W-1:1];
      end else if (reg_we) begin
         case (reg_sel)
            SEL_LEVELS: begin
               spi_lvl <= reg_wdata[LVL_W-1:0];
               sci_lvl <= reg_wdata[2*LVL_W-1:LVL_W];
            end
            SEL_ARBID:  arb_id <= reg_wdata[ID_W-1:0];
            SEL_VECTOR: vec_hi <= reg_wdata[VEC_W-1:1];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_LEVELS: begin
            reg_rdata[LVL_W-1:0]       = spi_lvl;
            reg_rdata[2*LVL_W-1:LVL_W] = sci_lvl;
         end
         SEL_ARBID:  reg_rdata[ID_W-1:0] = arb_id;
         SEL_VECTOR: reg_rdata = {vec_hi, 1'b1};
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sirq_level_select.sv
module sirq_level_select #(
   parameter int unsigned LVL_W = 3,
   localparam int unsigned NUM_LINES = (1 << LVL_W) - 1
) (
   input  logic                 spi_flag,
   input  logic                 sci_flag,
   input  logic [LVL_W-1:0]     spi_lvl,
   input  logic [LVL_W-1:0]     sci_lvl,
   output logic [LVL_W-1:0]     top_lvl,
   output logic                 top_is_spi,
   output logic [NUM_LINES-1:0] irq_lines
);
   logic [LVL_W-1:0] spi_eff;
   logic [LVL_W-1:0] sci_eff;

   always_comb begin
      spi_eff    = spi_flag ? spi_lvl : '0;
      sci_eff    = sci_flag ? sci_lvl : '0;
      top_is_spi = (spi_eff != '0) && (spi_eff >= sci_eff);
      top_lvl    = top_is_spi ? spi_eff : sci_eff;
   end

   for (genvar n = 1; n <= NUM_LINES; n++) begin : g_line
      assign irq_lines[n-1] = (top_lvl == LVL_W'(n));
   end
endmodule

// File: rtl/sirq_arbiter.sv
module sirq_arbiter #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned ID_W  = 4,
   localparam int unsigned CNT_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iack,
   input  logic [LVL_W-1:0] iack_level,
   input  logic [LVL_W-1:0] top_lvl,
   input  logic             top_is_spi,
   input  logic [ID_W-1:0]  arb_id,
   input  logic             arb_line,
   output logic             arb_out,
   output logic             arb_active,
   output logic             win_pulse,
   output logic             win_is_spi
);
   import sirq_pkg::*;

   arb_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             src_q;
   logic             eligible;

   assign eligible   = (arb_id != '0) && (top_lvl != '0) && (iack_level == top_lvl);
   assign arb_active = (state_q == ARB_SHIFT);
   assign arb_out    = arb_active && arb_id[cnt_q];
   assign win_pulse  = (state_q == ARB_WIN);
   assign win_is_spi = src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         cnt_q   <= '0;
         src_q   <= 1'b0;
      end else begin
         case (state_q)
            ARB_IDLE: if (iack) begin
               if (eligible) begin
                  state_q <= ARB_SHIFT;
                  cnt_q   <= CNT_W'(ID_W - 1);
                  src_q   <= top_is_spi;
               end else begin
                  state_q <= ARB_HOLD;
               end
            end
            ARB_SHIFT: begin
               if (!iack)                     state_q <= ARB_IDLE;
               else if (!arb_out && arb_line) state_q <= ARB_HOLD;
               else if (cnt_q == '0)          state_q <= ARB_WIN;
               else                           cnt_q   <= cnt_q - 1'b1;
            end
            ARB_WIN:  state_q <= ARB_HOLD;
            ARB_HOLD: if (!iack) state_q <= ARB_IDLE;
            default:  state_q <= ARB_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sirq_frontend.sv
module sirq_frontend #(
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned ID_W      = 4,
   parameter int unsigned VEC_W     = 8,
   parameter logic [7:0]  RESET_VEC = 8'h0F,
   localparam int unsigned NUM_LINES = (1 << LVL_W) - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_sel,
   input  logic                 reg_we,
   input  logic [VEC_W-1:0]     reg_wdata,
   output logic [VEC_W-1:0]     reg_rdata,
   input  logic                 spi_flag,
   input  logic                 sci_flag,
   output logic [NUM_LINES-1:0] irq_lines,
   input  logic                 iack,
   input  logic [LVL_W-1:0]     iack_level,
   output logic                 arb_out,
   input  logic                 arb_line,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_data
);
   if (2 * LVL_W > VEC_W) begin : g_bad_lvl
      $error("level fields do not fit in a register");
   end
   if (ID_W > VEC_W || ID_W < 1) begin : g_bad_id
      $error("arbitration ID width out of range");
   end
   if (VEC_W < 2 || VEC_W > 8) begin : g_bad_vec
      $error("vector width out of range");
   end

   logic [LVL_W-1:0] spi_lvl, sci_lvl, top_lvl;
   logic [ID_W-1:0]  arb_id;
   logic [VEC_W-1:1] vec_hi;
   logic             top_is_spi, arb_active, win_pulse, win_is_spi;

   sirq_regs #(.LVL_W(LVL_W), .ID_W(ID_W), .VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_lvl(spi_lvl),
      .sci_lvl(sci_lvl), .arb_id(arb_id), .vec_hi(vec_hi)
   );

   sirq_level_select #(.LVL_W(LVL_W)) lvl_i (
      .spi_flag(spi_flag), .sci_flag(sci_flag), .spi_lvl(spi_lvl),
      .sci_lvl(sci_lvl), .top_lvl(top_lvl), .top_is_spi(top_is_spi),
      .irq_lines(irq_lines)
   );

   sirq_arbiter #(.LVL_W(LVL_W), .ID_W(ID_W)) arb_i (
      .clk(clk), .rst_n(rst_n), .iack(iack), .iack_level(iack_level),
      .top_lvl(top_lvl), .top_is_spi(top_is_spi), .arb_id(arb_id),
      .arb_line(arb_line), .arb_out(arb_out), .arb_active(arb_active),
      .win_pulse(win_pulse), .win_is_spi(win_is_spi)
   );

   assign vec_valid = win_pulse;
   assign vec_data  = win_pulse ? {vec_hi, win_is_spi} : '0;
endmodule

// File: rtl/sirq_frontend_checker.sv
module sirq_frontend_checker #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned ID_W  = 4,
   parameter int unsigned VEC_W = 8,
   localparam int unsigned NUM_LINES = (1 << LVL_W) - 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           reg_sel,
   input logic [VEC_W-1:0]     reg_rdata,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic                 iack,
   input logic                 arb_out,
   input logic                 arb_line,
   input logic                 arb_active,
   input logic                 vec_valid,
   input logic [VEC_W-1:0]     vec_data,
   input logic [ID_W-1:0]      arb_id,
   input logic [VEC_W-1:1]     vec_hi
);
   assert_irq_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_lines));

   assert_zero_id_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_id == '0) |-> (!arb_out && !vec_valid));

   assert_vec_only_in_iack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> iack);

   assert_drop_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_active && !arb_out && arb_line) |=> (!arb_out && !vec_valid));

   assert_vec_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   assert_vec_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_data[VEC_W-1:1] == vec_hi));

   assert_line_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arb_out |-> arb_line);

   assert_vec_bit0_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2) |-> reg_rdata[0]);
endmodule

bind sirq_frontend sirq_frontend_checker #(.LVL_W(LVL_W), .ID_W(ID_W), .VEC_W(VEC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
   .irq_lines(irq_lines), .iack(iack), .arb_out(arb_out), .arb_line(arb_line),
   .arb_active(arb_active), .vec_valid(vec_valid), .vec_data(vec_data),
   .arb_id(arb_id), .vec_hi(vec_hi)
);

// File: tb/sirq_frontend_tb_top.sv
module sirq_frontend_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel_a = '0, sel_b = '0;
   logic       we_a = 1'b0, we_b = 1'b0;
   logic [7:0] wd_a = '0, wd_b = '0;
   logic [7:0] rd_a, rd_b;
   logic       spi_a = 1'b0, sci_a = 1'b0, spi_b = 1'b0, sci_b = 1'b0;
   logic [6:0] irq_a, irq_b;
   logic       iack = 1'b0;
   logic [2:0] iack_level = '0;
   logic       arb_a, arb_b, line;
   logic       vv_a, vv_b;
   logic [7:0] vd_a, vd_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   assign line = arb_a | arb_b;

   sirq_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel_a), .reg_we(we_a), .reg_wdata(wd_a),
      .reg_rdata(rd_a), .spi_flag(spi_a), .sci_flag(sci_a), .irq_lines(irq_a),
      .iack(iack), .iack_level(iack_level), .arb_out(arb_a), .arb_line(line),
      .vec_valid(vv_a), .vec_data(vd_a)
   );

   sirq_frontend rival_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel_b), .reg_we(we_b), .reg_wdata(wd_b),
      .reg_rdata(rd_b), .spi_flag(spi_b), .sci_flag(sci_b), .irq_lines(irq_b),
      .iack(iack), .iack_level(iack_level), .arb_out(arb_b), .arb_line(line),
      .vec_valid(vv_b), .vec_data(vd_b)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_top(input logic [2:0] sl, input logic sf,
                                          input logic [2:0] cl, input logic cf);
      logic [2:0] se, ce;
      se = sf ? sl : 3'd0;
      ce = cf ? cl : 3'd0;
      if (se != 0 && se >= ce) return {1'b1, se};
      return {1'b0, ce};
   endfunction

   function automatic logic [6:0] exp_lines(input logic [2:0] lvl);
      return (lvl == 0) ? 7'd0 : 7'(1 << (lvl - 1));
   endfunction

   task automatic wr(input bit rival, input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      if (rival) begin sel_b = s; wd_b = d; we_b = 1'b1; end
      else       begin sel_a = s; wd_a = d; we_a = 1'b1; end
      @(negedge clk);
      we_a = 1'b0; we_b = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      sel_a = s;
      #1 d = rd_a;
   endtask

   // runs one acknowledge cycle; reports edge index of each strobe (0 = none)
   task automatic ack(input logic [2:0] lvl, output int at_a, output int at_b,
                      output int cnt_a, output logic [7:0] v_a, output bit drove_a);
      at_a = 0; at_b = 0; cnt_a = 0; v_a = '0; drove_a = 1'b0;
      @(negedge clk);
      iack = 1'b1; iack_level = lvl;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (arb_a) drove_a = 1'b1;
         if (vv_a) begin cnt_a++; at_a = i; v_a = vd_a; end
         if (vv_b) at_b = i;
      end
      iack = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      logic [7:0] r, v;
      int ta, tb, ca;
      bit dr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      rd(2'd2, r); check(r == 8'h0F, "R8 vector reset", r, 8'h0F);
      rd(2'd0, r); check(r == 8'h00, "R8 levels reset", r, 0);
      rd(2'd1, r); check(r == 8'h00, "R8 id reset", r, 0);
      check(irq_a == 0 && !vv_a, "R8 outputs reset", {irq_a, vv_a}, 0);

      // R9 bit 0 of vector
      wr(0, 2'd2, 8'hA4); rd(2'd2, r); check(r == 8'hA5, "R9 write bit0 ignored", r, 8'hA5);
      wr(0, 2'd2, 8'h36); rd(2'd2, r); check(r == 8'h37, "R9 read bit0 one", r, 8'h37);

      // R11 field layout
      wr(0, 2'd0, 8'b00_101_011); rd(2'd0, r); check(r == 8'h2B, "R11 levels readback", r, 8'h2B);
      wr(0, 2'd1, 8'h09); rd(2'd1, r); check(r == 8'h09, "R11 id readback", r, 8'h09);

      // R1 each level for SPI alone
      for (int n = 1; n <= 7; n++) begin
         wr(0, 2'd0, 8'(n));
         spi_a = 1'b1; sci_a = 1'b0;
         #1 check(irq_a == exp_lines(3'(n)), "R1 line per level", irq_a, exp_lines(3'(n)));
      end
      // R2 disabled sources
      wr(0, 2'd0, 8'b00_000_000); spi_a = 1'b1; sci_a = 1'b1;
      #1 check(irq_a == 0, "R2 both disabled", irq_a, 0);
      ack(3'd0, ta, tb, ca, v, dr); check(ca == 0, "R2 no vector when disabled", ca, 0);
      wr(0, 2'd0, 8'b00_100_000); spi_a = 1'b1; sci_a = 1'b0;
      #1 check(irq_a == 0, "R2 SPI level zero", irq_a, 0);

      // R3 tie, SPI preferred
      wr(0, 2'd0, 8'b00_101_101); spi_a = 1'b1; sci_a = 1'b1;
      ack(3'd5, ta, tb, ca, v, dr);
      check(ca == 1 && v == 8'h37, "R3 tie SPI wins", v, 8'h37);
      wr(0, 2'd0, 8'b00_110_101);
      ack(3'd6, ta, tb, ca, v, dr);
      check(ca == 1 && v == 8'h36, "R3 higher SCI wins", v, 8'h36);
      // R7 timing
      check(ta == 5, "R7 strobe cycle", ta, 5);

      // R4 mismatch
      ack(3'd5, ta, tb, ca, v, dr);
      check(ca == 0 && !dr, "R4 level mismatch no contend", {ca[7:0], 7'd0, dr}, 0);

      // R10 hold after ack
      #1 check(irq_a == exp_lines(3'd6), "R10 line held after ack", irq_a, exp_lines(3'd6));
      sci_a = 1'b0;
      #1 check(irq_a == exp_lines(3'd5), "R10 falls to remaining source", irq_a, exp_lines(3'd5));
      spi_a = 1'b0;
      #1 check(irq_a == 0, "R10 cleared flags", irq_a, 0);

      // R5 zero id
      wr(0, 2'd1, 8'h00); wr(0, 2'd0, 8'b00_000_011); spi_a = 1'b1;
      ack(3'd3, ta, tb, ca, v, dr);
      check(ca == 0 && !dr, "R5 zero id silent", {ca[7:0], 7'd0, dr}, 0);

      // R6 rival with higher id
      wr(0, 2'd1, 8'h05); wr(1, 2'd1, 8'h0A); wr(1, 2'd0, 8'h03); wr(1, 2'd2, 8'h80);
      spi_b = 1'b1;
      ack(3'd3, ta, tb, ca, v, dr);
      check(ca == 0 && tb == 5, "R6 higher rival wins", {ca[15:0], tb[15:0]}, 32'h5);
      wr(1, 2'd1, 8'h04);
      ack(3'd3, ta, tb, ca, v, dr);
      check(ca == 1 && tb == 0 && v == 8'h37, "R6 dut outranks rival", v, 8'h37);
      spi_b = 1'b0;

      // random mix
      for (int it = 0; it < 80; it++) begin
         logic [2:0] sl, cl, rl, al;
         logic [3:0] id, rid, t, rt;
         logic [7:0] vec;
         logic sf, cf, rf;
         bit ca_exp, cb_exp, a_wins;
         sl = 3'($urandom_range(0, 7)); cl = 3'($urandom_range(0, 7));
         rl = 3'($urandom_range(0, 7));
         sf = 1'($urandom); cf = 1'($urandom); rf = 1'($urandom);
         id = 4'($urandom_range(0, 15)); rid = 4'($urandom_range(1, 15));
         if (rid == id) rid = (id == 4'd15) ? 4'd1 : id + 4'd1;
         vec = 8'($urandom);
         wr(0, 2'd0, {2'b00, cl, sl}); wr(0, 2'd1, {4'd0, id}); wr(0, 2'd2, vec);
         wr(1, 2'd0, {5'd0, rl}); wr(1, 2'd1, {4'd0, rid});
         spi_a = sf; sci_a = cf; spi_b = rf; sci_b = 1'b0;
         t  = exp_top(sl, sf, cl, cf);
         rt = exp_top(rl, rf, 3'd0, 1'b0);
         al = ($urandom_range(0, 1) == 1) ? t[2:0] : 3'($urandom_range(0, 7));
         #1 check(irq_a == exp_lines(t[2:0]), "R1 random lines", irq_a, exp_lines(t[2:0]));
         ca_exp = (t[2:0] != 0) && (al == t[2:0]) && (id != 0);
         cb_exp = (rt[2:0] != 0) && (al == rt[2:0]);
         a_wins = ca_exp && (!cb_exp || id > rid);
         ack(al, ta, tb, ca, v, dr);
         check(ca == (a_wins ? 1 : 0), "R4 random contend", ca, a_wins);
         if (a_wins)
            check(ta == 5 && v == {vec[7:1], t[3]}, "R7 random vector", v, {vec[7:1], t[3]});
         if (cb_exp && !a_wins)
            check(tb == 5, "R6 random rival wins", tb, 5);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule